// File: doc/BRIEF.md
# Dual-Channel Counter PWM with Centre-Aligned Option

This block generates two pulse-width-modulated outputs from one shared 16-bit counter. The counter steps once for every cycle in which an external divider raises the count strobe. In edge-aligned mode it climbs from 0 to a programmable limit and restarts at 0. In centre-aligned mode it climbs to the limit and then falls back to 0, so that each pulse sits in the middle of the period. Each output channel compares its own threshold with the counter and can be inverted on its own. A sticky period flag records each wrap, and software clears it by writing a one.

The counter is run by a three-state machine. OFF is the disabled state: the counter and outputs hold. UP counts upward, and DOWN counts downward (centre-aligned mode only). The transitions are:
- OFF→UP when the enable rises. This cycle loads the configuration and does not count.
- UP→UP on each strobe below the limit. At the limit in edge-aligned mode, the counter also restarts at 0, which is a wrap.
- UP→DOWN at the limit in centre-aligned mode. The counter holds for that strobe.
- DOWN→DOWN on each strobe above 0.
- DOWN→UP at 0. The counter holds for that strobe, and this is a wrap.
- Any state→OFF when the enable falls.

The limit, thresholds, inversions and mode are copied into active registers only on the enable cycle or on a wrap.

Top module: `pwm_slice`

## Requirements
- R1: While enabled, each channel output before inversion is 1 exactly when its active threshold is greater than the counter value.
- R2: A threshold of 0 keeps the output low. A threshold of limit+1 keeps it high for the whole period.
- R3: In edge-aligned mode the counter goes up by one on each strobe. A strobe at the limit returns it to 0, which gives a period of limit+1 strobes.
- R4: In centre-aligned mode the counter counts 0 up to the limit, repeats the limit once, counts down to 0 and repeats 0 once. This gives a period of 2*(limit+1) strobes.
- R5: While enabled, the counter changes only in cycles with the count strobe high (apart from direct writes).
- R6: An asserted invert bit complements that channel's output.
- R7: The period flag sets on a wrap: the limit→0 step in edge-aligned mode, or the turn at 0 in centre-aligned mode. It stays set until a clear pulse. A wrap in the same cycle as a clear leaves it set.
- R8: New limit, threshold, invert and mode values take effect only at the next wrap or on the enable cycle, never mid-period.
- R9: While disabled, the counter and both outputs hold whatever the configuration inputs do. The enable cycle loads the configuration without advancing the counter.
- R10: A counter write loads the written value at the next clock edge, overriding any step.
- R11: After reset the counter is 0, the flag is 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Slice run enable |
| cen_i | input | 1 | Count strobe from the external divider |
| phase_correct_i | input | 1 | 1 selects centre-aligned up/down counting |
| top_i | input | 16 | Counter limit |
| cmp_a_i | input | 16 | Channel A threshold |
| cmp_b_i | input | 16 | Channel B threshold |
| inv_a_i | input | 1 | Channel A output invert |
| inv_b_i | input | 1 | Channel B output invert |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 16 | Counter write value |
| wrap_clr_i | input | 1 | Write-one pulse clearing the period flag |
| pwm_a_o | output | 1 | Channel A output |
| pwm_b_o | output | 1 | Channel B output |
| cnt_o | output | 16 | Current counter value |
| wrap_flag_o | output | 1 | Sticky period flag |

## Verification
The counter and the flag are registers, and the outputs are decoded from registers without further delay. Every result of a stimulus applied before an edge is therefore due after that single edge, and a configuration change becomes visible only after the edge that carries the next wrap or the enable. The driver pushes one expected item per clock edge and then changes inputs just after the falling edge. The monitor pops and compares at each falling edge, so every comparison falls exactly one edge after its stimulus. Deferred configuration is checked by predicting old values up to the wrap and new values from the wrap onward.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } pwm_state_e;
endpackage

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow #(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [CNT_W-1:0]           top_i,
    input  logic                       phase_i,
    input  logic [NCH-1:0][CNT_W-1:0]  cmp_i,
    input  logic [NCH-1:0]             inv_i,
    output logic [CNT_W-1:0]           top_o,
    output logic                       phase_o,
    output logic [NCH-1:0][CNT_W-1:0]  cmp_o,
    output logic [NCH-1:0]             inv_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_o   <= '1;
            phase_o <= 1'b0;
            cmp_o   <= '0;
            inv_o   <= '0;
        end else if (load_i) begin
            top_o   <= top_i;
            phase_o <= phase_i;
            cmp_o   <= cmp_i;
            inv_o   <= inv_i;
        end
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_slice_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             cen_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             wrap_clr_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             phase_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_flag_o,
    output logic             load_o
);
    pwm_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wrap_evt;
    logic             flag_q;

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        wrap_evt = 1'b0;
        if (!en_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_UP;
                ST_UP: begin
                    if (cen_i) begin
                        if (cnt_q >= top_i) begin
                            if (phase_i) begin
                                state_d = ST_DOWN;
                            end else begin
                                cnt_d    = '0;
                                wrap_evt = 1'b1;
                            end
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_DOWN: begin
                    if (cen_i) begin
                        if (cnt_q == '0) begin
                            state_d  = ST_UP;
                            wrap_evt = 1'b1;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
        if (cnt_wr_i) begin
            cnt_d    = cnt_wdata_i;
            wrap_evt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (wrap_evt) flag_q <= 1'b1;
            else if (wrap_clr_i) flag_q <= 1'b0;
        end
    end

    assign cnt_o       = cnt_q;
    assign wrap_flag_o = flag_q;
    assign load_o      = wrap_evt || (state_q == ST_OFF && en_i);

    // R9
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !cnt_wr_i) |=> $stable(cnt_q));
    // R5
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_i && !cnt_wr_i) |=> $stable(cnt_q));
    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && en_i && cen_i && !cnt_wr_i && cnt_q < top_i)
        |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R7
    wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> flag_q);
    // R7
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !wrap_clr_i) |=> flag_q);
    // R4
    down_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN) |-> phase_i);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             inv_i,
    output logic             pwm_o
);
    logic raw;
    assign raw   = (cmp_i > cnt_i);
    assign pwm_o = raw ^ inv_i;
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
    import pwm_slice_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             cen_i,
    input  logic             phase_correct_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    input  logic             inv_a_i,
    input  logic             inv_b_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             wrap_clr_i,
    output logic             pwm_a_o,
    output logic             pwm_b_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_flag_o
);
    logic                          load;
    logic [CNT_W-1:0]              top_act;
    logic                          phase_act;
    logic [NUM_CH-1:0][CNT_W-1:0]  cmp_act;
    logic [NUM_CH-1:0]             inv_act;
    logic [NUM_CH-1:0]             pwm;
    logic [CNT_W-1:0]              cnt;

    pwm_cfg_shadow #(.CNT_W(CNT_W), .NCH(NUM_CH)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .top_i   (top_i),
        .phase_i (phase_correct_i),
        .cmp_i   ({cmp_b_i, cmp_a_i}),
        .inv_i   ({inv_b_i, inv_a_i}),
        .top_o   (top_act),
        .phase_o (phase_act),
        .cmp_o   (cmp_act),
        .inv_o   (inv_act)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .cen_i       (cen_i),
        .cnt_wr_i    (cnt_wr_i),
        .cnt_wdata_i (cnt_wdata_i),
        .wrap_clr_i  (wrap_clr_i),
        .top_i       (top_act),
        .phase_i     (phase_act),
        .cnt_o       (cnt),
        .wrap_flag_o (wrap_flag_o),
        .load_o      (load)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_chan (
            .cnt_i (cnt),
            .cmp_i (cmp_act[ch]),
            .inv_i (inv_act[ch]),
            .pwm_o (pwm[ch])
        );
    end

    assign pwm_a_o = pwm[0];
    assign pwm_b_o = pwm[1];
    assign cnt_o   = cnt;

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !cnt_wr_i) |=> ($stable(pwm_a_o) && $stable(pwm_b_o)));
    // R8
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(top_act) && $stable(cmp_act) && $stable(inv_act)));
endmodule

// File: tb/pwm_slice_bench.sv
`timescale 1ns/1ps
module pwm_slice_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0, cen_i = 1'b1, phase_correct_i = 1'b0;
    logic [15:0] top_i = 16'd4, cmp_a_i = 16'd2, cmp_b_i = 16'd5;
    logic        inv_a_i = 1'b0, inv_b_i = 1'b0;
    logic        cnt_wr_i = 1'b0, wrap_clr_i = 1'b0;
    logic [15:0] cnt_wdata_i = '0;
    logic        pwm_a_o, pwm_b_o, wrap_flag_o;
    logic [15:0] cnt_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] cnt;
        logic        a;
        logic        b;
        logic        flag;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    pwm_slice u_pwm_slice (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .cen_i(cen_i),
        .phase_correct_i(phase_correct_i), .top_i(top_i),
        .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i), .inv_a_i(inv_a_i), .inv_b_i(inv_b_i),
        .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i), .wrap_clr_i(wrap_clr_i),
        .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o), .cnt_o(cnt_o), .wrap_flag_o(wrap_flag_o)
    );

    // Monitor: compares one expected item per falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (cnt_o !== e.cnt || pwm_a_o !== e.a || pwm_b_o !== e.b || wrap_flag_o !== e.flag) begin
                errors++;
                $display("FAIL %s: got cnt=%0d a=%b b=%b flag=%b, expected cnt=%0d a=%b b=%b flag=%b",
                         e.req, cnt_o, pwm_a_o, pwm_b_o, wrap_flag_o, e.cnt, e.a, e.b, e.flag);
            end
        end
    end

    // Driver: pushes the expectation for the coming edge, then waits past it.
    task automatic tick(input logic [15:0] c, input logic a, input logic b,
                        input logic f, input string req);
        exp_t e;
        e.cnt = c; e.a = a; e.b = b; e.flag = f; e.req = req;
        exp_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        // R11 reset state
        checks++;
        if (cnt_o !== 16'd0 || pwm_a_o !== 1'b0 || pwm_b_o !== 1'b0 || wrap_flag_o !== 1'b0) begin
            errors++;
            $display("FAIL R11: got cnt=%0d a=%b b=%b flag=%b, expected 0 0 0 0",
                     cnt_o, pwm_a_o, pwm_b_o, wrap_flag_o);
        end

        // Edge-aligned, limit 4, A threshold 2, B threshold limit+1
        en_i = 1'b1;
        tick(16'd0, 1'b1, 1'b1, 1'b0, "R9 enable load no step");
        for (int n = 1; n <= 12; n++) begin
            logic [15:0] c;
            c = 16'(n % 5);
            tick(c, c < 16'd2, 1'b1, n >= 5, "R1/R2/R3/R7 edge-aligned");
        end
        wrap_clr_i = 1'b1;
        tick(16'd3, 1'b0, 1'b1, 1'b0, "R7 clear");
        wrap_clr_i = 1'b0;
        tick(16'd4, 1'b0, 1'b1, 1'b0, "R7 stays clear");
        tick(16'd0, 1'b1, 1'b1, 1'b1, "R7 re-set");
        // Threshold change deferred to wrap
        cmp_b_i = 16'd0;
        tick(16'd1, 1'b1, 1'b1, 1'b1, "R8 deferred threshold");
        tick(16'd2, 1'b0, 1'b1, 1'b1, "R8 deferred threshold");
        tick(16'd3, 1'b0, 1'b1, 1'b1, "R8 deferred threshold");
        tick(16'd4, 1'b0, 1'b1, 1'b1, "R8 deferred threshold");
        wrap_clr_i = 1'b1;
        tick(16'd0, 1'b1, 1'b0, 1'b1, "R7 wrap beats clear / R2 zero low");
        wrap_clr_i = 1'b0;
        inv_a_i = 1'b1;
        tick(16'd1, 1'b1, 1'b0, 1'b1, "R8 deferred invert");
        tick(16'd2, 1'b0, 1'b0, 1'b1, "R8 deferred invert");
        tick(16'd3, 1'b0, 1'b0, 1'b1, "R8 deferred invert");
        tick(16'd4, 1'b0, 1'b0, 1'b1, "R2 zero low");
        tick(16'd0, 1'b0, 1'b0, 1'b1, "R6 invert");
        tick(16'd1, 1'b0, 1'b0, 1'b1, "R6 invert");
        tick(16'd2, 1'b1, 1'b0, 1'b1, "R6 invert");
        // Strobe gating
        cen_i = 1'b0;
        tick(16'd2, 1'b1, 1'b0, 1'b1, "R5 no strobe");
        tick(16'd2, 1'b1, 1'b0, 1'b1, "R5 no strobe");
        cen_i = 1'b1;
        tick(16'd3, 1'b1, 1'b0, 1'b1, "R5 strobe");
        cen_i = 1'b0;
        tick(16'd3, 1'b1, 1'b0, 1'b1, "R5 no strobe");
        cen_i = 1'b1;
        tick(16'd4, 1'b1, 1'b0, 1'b1, "R5 strobe");
        tick(16'd0, 1'b0, 1'b0, 1'b1, "R3 wrap");
        // Counter write
        cnt_wr_i = 1'b1;
        cnt_wdata_i = 16'd3;
        tick(16'd3, 1'b1, 1'b0, 1'b1, "R10 write");
        cnt_wr_i = 1'b0;
        tick(16'd4, 1'b1, 1'b0, 1'b1, "R10 after write");
        // Disable: hold regardless of configuration
        en_i = 1'b0;
        tick(16'd4, 1'b1, 1'b0, 1'b1, "R9 disable hold");
        cmp_a_i = 16'd0; inv_a_i = 1'b0; top_i = 16'd2; cmp_b_i = 16'd3;
        for (int k = 0; k < 3; k++)
            tick(16'd4, 1'b1, 1'b0, 1'b1, "R9 config ignored while off");

        // Centre-aligned, limit 3, A threshold 2, B threshold limit+1
        phase_correct_i = 1'b1; top_i = 16'd3; cmp_a_i = 16'd2; cmp_b_i = 16'd4;
        cnt_wr_i = 1'b1; cnt_wdata_i = 16'd0; wrap_clr_i = 1'b1;
        tick(16'd0, 1'b0, 1'b0, 1'b0, "R10 write while off / R7 clear");
        cnt_wr_i = 1'b0; wrap_clr_i = 1'b0;
        en_i = 1'b1;
        tick(16'd0, 1'b1, 1'b1, 1'b0, "R9 enable load");
        for (int k = 1; k <= 17; k++) begin
            int m;
            logic [15:0] c;
            m = k % 8;
            c = (m <= 3) ? 16'(m) : 16'(7 - m);
            tick(c, c < 16'd2, 1'b1, k >= 8, "R4/R2/R7 centre-aligned");
        end

        wait (exp_q.size() == 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule